// File: doc/BRIEF.md
# Machine External Interrupt Trap Entry

This block decides, at each instruction boundary of a small 32-bit core, whether a single machine-level external interrupt is entered. A rising edge on the interrupt request line is caught in a sticky flag, whether or not an instruction retires in that cycle. When an instruction retires, the block reads the machine status word and the interrupt-pending word from the CSR file. If the flag is set, the global interrupt-enable bit is on and the external-pending bit is off, the block takes the trap. It then issues CSR writes for the pending, exception-PC and cause registers, and a one-cycle redirect that loads the program counter from the trap-vector register.

If the global enable is off, the request stays latched and the next boundary tries again. After an entry, the first boundary that finds no request latched clears the external-pending bit. That clear is issued only once until the next entry. All writes and the redirect are combinational in the retire cycle, so the CSR file and fetch unit take them on the same clock edge that retires the instruction.

Top module: `mei_trap_entry`

## Requirements
- R1: After synchronous active-high reset, no request is latched and the clear-once tracker reads "already cleared". A retiring instruction with no request causes no CSR write and no redirect.
- R2: A 0-to-1 transition of `irq_i` latches a request even when `retire_i` is low. A level held high after the request has been consumed does not latch another one.
- R3: When `retire_i` is low, none of `pend_we_o`, `epc_we_o`, `cause_we_o` or `redirect_o` is asserted.
- R4: With a request latched and status bit 3 (global enable) equal to 0, a retire causes no write and no redirect. The request stays latched and is entered at a later retire once bit 3 is 1.
- R5: Entry happens at a retire with a request latched, status bit 3 = 1 and pending bit 11 = 0. In that cycle: the pending write carries the read value with bit 11 set; the exception-PC write carries `next_pc_i`; the cause write carries 0x80000000; `redirect_o` is high with `redirect_pc_o` equal to the trap-vector read value, low two bits unmasked.
- R6: With a request latched and pending bit 11 already 1, a retire causes no write and no redirect, and the request stays latched.
- R7: After an entry, the first retire that finds no request latched writes the pending read value with bit 11 cleared. Later retires write nothing until the next entry.
- R8: If a new rising edge of `irq_i` arrives in the same cycle as an entry, the request stays latched for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | External interrupt request (edge latched) |
| retire_i | input | 1 | Instruction boundary strobe |
| next_pc_i | input | 32 | PC of the next instruction |
| status_rd_i | input | 32 | Machine status CSR read value (bit 3 = global enable) |
| tvec_rd_i | input | 32 | Trap-vector CSR read value |
| pend_rd_i | input | 32 | Interrupt-pending CSR read value (bit 11 = external) |
| pend_we_o | output | 1 | Pending CSR write enable |
| pend_wdata_o | output | 32 | Pending CSR write data |
| epc_we_o | output | 1 | Exception-PC CSR write enable |
| epc_wdata_o | output | 32 | Exception-PC CSR write data |
| cause_we_o | output | 1 | Cause CSR write enable |
| cause_wdata_o | output | 32 | Cause CSR write data |
| redirect_o | output | 1 | One-cycle PC redirect |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
The bench goes after four corner cases:
- A request that arrives while the global enable is off. A design that drops it would never redirect.
- A request that arrives while the pending bit is already set. A design that ignores that bit would enter twice.
- The boundary after an entry. A design with no working tracker would clear the pending bit on every later retire, or never clear it.
- A new edge that lands on the entry cycle. A design where the consume wins would lose that second interrupt.

A long pseudo-random sweep over the request edge, retire, enable, pending bit and address values compares every write and the redirect with an arithmetic model of these rules.

// File: rtl/mei_pkg.sv
package mei_pkg;
    localparam int XLEN      = 32;
    localparam int MIE_BIT   = 3;
    localparam int MEIP_BIT  = 11;
    localparam int CAUSE_EXT = 0;

    typedef struct packed {
        logic prev;
        logic flag;
    } latch_state_t;

    typedef struct packed {
        logic cleared;
    } ctrl_state_t;
endpackage

// File: rtl/mei_req_latch.sv
module mei_req_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic irq_i,
    input  logic consume_i,
    output logic req_o
);
    import mei_pkg::*;

    latch_state_t st_d, st_q;
    logic         rise;

    always_comb begin
        st_d      = st_q;
        rise      = irq_i & ~st_q.prev;
        st_d.prev = irq_i;
        // a fresh edge wins over consumption in the same cycle
        st_d.flag = rise | (st_q.flag & ~consume_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.flag;

    // R2
    edge_latched_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_i) |=> req_o);
    // R8
    edge_beats_consume_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(irq_i) && consume_i) |=> req_o);
endmodule

// File: rtl/mei_entry_ctrl.sv
module mei_entry_ctrl #(
    parameter int XLEN     = mei_pkg::XLEN,
    parameter int MIE_BIT  = mei_pkg::MIE_BIT,
    parameter int MEIP_BIT = mei_pkg::MEIP_BIT
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            retire_i,
    input  logic            req_i,
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] pend_i,
    output logic            take_o,
    output logic            clear_o
);
    import mei_pkg::*;

    ctrl_state_t st_d, st_q;
    logic        enabled;
    logic        already_pending;
    logic        unused_status;

    assign enabled         = status_i[MIE_BIT];
    assign already_pending = pend_i[MEIP_BIT];
    assign unused_status   = ^status_i;

    always_comb begin
        st_d    = st_q;
        take_o  = 1'b0;
        clear_o = 1'b0;
        if (retire_i) begin
            if (req_i) begin
                if (enabled && !already_pending) begin
                    take_o       = 1'b1;
                    st_d.cleared = 1'b0;
                end
            end else if (!st_q.cleared) begin
                clear_o      = 1'b1;
                st_d.cleared = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cleared <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    clear_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_o |=> !clear_o);
    // R4
    take_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> status_i[MIE_BIT]);
    // R6
    take_needs_idle_pend_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> !pend_i[MEIP_BIT]);
endmodule

// File: rtl/mei_csr_pack.sv
module mei_csr_pack #(
    parameter int XLEN      = mei_pkg::XLEN,
    parameter int MEIP_BIT  = mei_pkg::MEIP_BIT,
    parameter int CAUSE_EXT = mei_pkg::CAUSE_EXT
) (
    input  logic            take_i,
    input  logic            clear_i,
    input  logic [XLEN-1:0] next_pc_i,
    input  logic [XLEN-1:0] tvec_i,
    input  logic [XLEN-1:0] pend_i,
    output logic            pend_we_o,
    output logic [XLEN-1:0] pend_wdata_o,
    output logic            epc_we_o,
    output logic [XLEN-1:0] epc_wdata_o,
    output logic            cause_we_o,
    output logic [XLEN-1:0] cause_wdata_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);
    localparam logic [XLEN-1:0] PEND_MASK = XLEN'(1) << MEIP_BIT;
    localparam logic [XLEN-1:0] CAUSE_VAL = (XLEN'(1) << (XLEN-1)) | XLEN'(CAUSE_EXT);

    always_comb begin
        pend_we_o     = take_i | clear_i;
        pend_wdata_o  = take_i ? (pend_i | PEND_MASK) : (pend_i & ~PEND_MASK);
        epc_we_o      = take_i;
        epc_wdata_o   = next_pc_i;
        cause_we_o    = take_i;
        cause_wdata_o = CAUSE_VAL;
        redirect_o    = take_i;
        redirect_pc_o = tvec_i;
    end
endmodule

// File: rtl/mei_trap_entry.sv
module mei_trap_entry #(
    parameter int XLEN      = mei_pkg::XLEN,
    parameter int MIE_BIT   = mei_pkg::MIE_BIT,
    parameter int MEIP_BIT  = mei_pkg::MEIP_BIT,
    parameter int CAUSE_EXT = mei_pkg::CAUSE_EXT
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            irq_i,
    input  logic            retire_i,
    input  logic [XLEN-1:0] next_pc_i,
    input  logic [XLEN-1:0] status_rd_i,
    input  logic [XLEN-1:0] tvec_rd_i,
    input  logic [XLEN-1:0] pend_rd_i,
    output logic            pend_we_o,
    output logic [XLEN-1:0] pend_wdata_o,
    output logic            epc_we_o,
    output logic [XLEN-1:0] epc_wdata_o,
    output logic            cause_we_o,
    output logic [XLEN-1:0] cause_wdata_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);
    logic req;
    logic take;
    logic clear;

    mei_req_latch u_latch (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .irq_i     (irq_i),
        .consume_i (take),
        .req_o     (req)
    );

    mei_entry_ctrl #(
        .XLEN     (XLEN),
        .MIE_BIT  (MIE_BIT),
        .MEIP_BIT (MEIP_BIT)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .retire_i (retire_i),
        .req_i    (req),
        .status_i (status_rd_i),
        .pend_i   (pend_rd_i),
        .take_o   (take),
        .clear_o  (clear)
    );

    mei_csr_pack #(
        .XLEN      (XLEN),
        .MEIP_BIT  (MEIP_BIT),
        .CAUSE_EXT (CAUSE_EXT)
    ) u_pack (
        .take_i        (take),
        .clear_i       (clear),
        .next_pc_i     (next_pc_i),
        .tvec_i        (tvec_rd_i),
        .pend_i        (pend_rd_i),
        .pend_we_o     (pend_we_o),
        .pend_wdata_o  (pend_wdata_o),
        .epc_we_o      (epc_we_o),
        .epc_wdata_o   (epc_wdata_o),
        .cause_we_o    (cause_we_o),
        .cause_wdata_o (cause_wdata_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    // R3
    quiet_off_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !retire_i |-> !(pend_we_o || epc_we_o || cause_we_o || redirect_o));
    // R5
    redirect_with_writes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        redirect_o |-> (epc_we_o && cause_we_o && pend_we_o && pend_wdata_o[MEIP_BIT]));
    // R5
    redirect_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        redirect_o |-> (redirect_pc_o == tvec_rd_i && epc_wdata_o == next_pc_i));
endmodule

// File: tb/mei_trap_entry_tb_top.sv
`timescale 1ns/1ps
module mei_trap_entry_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        irq, retire;
    logic [31:0] next_pc, status, tvec, pend;
    logic        pend_we, epc_we, cause_we, redirect;
    logic [31:0] pend_wdata, epc_wdata, cause_wdata, redirect_pc;

    int n_cmp  = 0;
    int n_fail = 0;
    logic m_prev, m_lat, m_clr;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    mei_trap_entry dut_i (
        .clk_i(clk), .rst_i(rst), .irq_i(irq), .retire_i(retire),
        .next_pc_i(next_pc), .status_rd_i(status), .tvec_rd_i(tvec),
        .pend_rd_i(pend), .pend_we_o(pend_we), .pend_wdata_o(pend_wdata),
        .epc_we_o(epc_we), .epc_wdata_o(epc_wdata), .cause_we_o(cause_we),
        .cause_wdata_o(cause_wdata), .redirect_o(redirect),
        .redirect_pc_o(redirect_pc)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic step(input logic i, input logic r, input logic [31:0] st,
                        input logic [31:0] pd, input logic [31:0] tv,
                        input logic [31:0] pc, input string tag);
        logic take, clr, rise;
        string t;
        @(negedge clk);
        irq = i; retire = r; status = st; pend = pd; tvec = tv; next_pc = pc;
        #1;
        take = r & m_lat & st[3] & ~pd[11];
        clr  = r & ~m_lat & ~m_clr;
        t = tag;
        if (t == "") begin
            if (take) t = "R5";
            else if (clr) t = "R7";
            else if (!r) t = "R3";
            else if (m_lat && !st[3]) t = "R4";
            else if (m_lat) t = "R6";
            else t = "R7";
        end
        chk({31'd0, redirect}, {31'd0, take}, {t, " redirect"});
        chk({31'd0, epc_we},   {31'd0, take}, {t, " epc_we"});
        chk({31'd0, cause_we}, {31'd0, take}, {t, " cause_we"});
        chk({31'd0, pend_we},  {31'd0, take | clr}, {t, " pend_we"});
        if (take) begin
            chk(redirect_pc, tv, {t, " redirect_pc"});
            chk(epc_wdata, pc, {t, " epc_wdata"});
            chk(cause_wdata, 32'h8000_0000, {t, " cause_wdata"});
            chk(pend_wdata, pd | 32'h800, {t, " pend set"});
        end
        if (clr) chk(pend_wdata, pd & ~32'h800, {t, " pend clear"});
        rise  = i & ~m_prev;
        m_lat = rise | (m_lat & ~take);
        if (take) m_clr = 1'b0;
        else if (clr) m_clr = 1'b1;
        m_prev = i;
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; irq = 0; retire = 0; status = 0; pend = 0; tvec = 0; next_pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_prev = 0; m_lat = 0; m_clr = 1;

        // R1: nothing latched, tracker already cleared
        step(0, 1, 32'h8, 32'h0, 32'h100, 32'h40, "R1");
        // R2: edge without retire, caught later
        step(1, 0, 32'h8, 32'h0, 32'h100, 32'h44, "R2");
        step(0, 0, 32'h8, 32'h0, 32'h100, 32'h44, "R2");
        step(0, 1, 32'h8, 32'h0, 32'h200, 32'h48, "R2");
        // R7: clear once
        step(0, 1, 32'h8, 32'h800, 32'h200, 32'h4c, "R7");
        step(0, 1, 32'h8, 32'h0,   32'h200, 32'h50, "R7");
        // R3: no action off boundary
        step(1, 0, 32'h8, 32'h0, 32'h300, 32'h54, "R3");
        step(0, 0, 32'h8, 32'h0, 32'h300, 32'h58, "R3");
        // R5: unmasked vector, other pending bits kept
        step(0, 1, 32'hFFFF_FFFF, 32'h0000_0088, 32'h0000_1003, 32'h5c, "R5");
        step(0, 1, 32'h8, 32'h0000_0888, 32'h0, 32'h60, "R7");
        // R4: deferred by global enable
        step(1, 1, 32'h0, 32'h0, 32'h400, 32'h64, "R4");
        step(0, 1, 32'hFFFF_FFF7, 32'h0, 32'h400, 32'h68, "R4");
        step(0, 1, 32'h8, 32'h0, 32'h404, 32'h6c, "R4");
        step(0, 1, 32'h8, 32'h800, 32'h0, 32'h70, "R7");
        // R6: already pending blocks entry, request kept
        step(1, 1, 32'h8, 32'h800, 32'h500, 32'h74, "R6");
        step(0, 1, 32'h8, 32'h800, 32'h500, 32'h78, "R6");
        step(0, 1, 32'h8, 32'h0, 32'h500, 32'h7c, "R6");
        // R8: edge on the entry cycle survives
        step(1, 0, 32'h8, 32'h0, 32'h600, 32'h80, "R8");
        step(0, 0, 32'h8, 32'h0, 32'h600, 32'h84, "R8");
        step(1, 1, 32'h8, 32'h0, 32'h600, 32'h88, "R8");
        step(1, 1, 32'h8, 32'h0, 32'h604, 32'h8c, "R8");
        // R2: held level does not relatch
        step(1, 1, 32'h8, 32'h0, 32'h608, 32'h90, "R2");
        step(1, 1, 32'h8, 32'h0, 32'h608, 32'h94, "R2");

        // sweep
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] a, b;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            a = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            b = rng;
            step(a[0], a[1] | a[2], {a[31:4], a[3] | a[5], a[2:0]},
                 (b[0] && b[1]) ? (b | 32'h800) : (b & ~32'h800),
                 a ^ b, {b[15:0], a[15:0]}, "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule